// File: doc/BRIEF.md
# IEC958 Audio Subframe Formatter

This block sits on the audio side of an HDMI transmitter. Each input word is one PCM sample from an interleaved multichannel stream. The block turns each word into a 32-bit subframe word that the downstream audio packetiser consumes. Samples arrive over a valid/ready handshake in channel order, and the block never reorders them.

The block has two formats. In linear mode it takes a 24-bit sample and adds three things: a channel-status bit, an even-parity bit and a block-start flag. The channel-status sequence is built inside the block from a 32-bit consumer status word, and the channel number is written into it separately for each channel. In passthrough mode the input words are already complete subframes, so the block only moves their bits into the output positions.

Software loads the format, the channel count (2 to 8) and the status word with a one-cycle load strobe before a stream starts. A separate restart strobe rewinds the frame and channel position without changing the configuration. Each formatted word is held in a single output register, and backpressure on that register stalls the input.

Top module: `iec_subframe_fmt`

## Requirements
- R1: In linear mode, output bits 23..0 equal input bits 23..0. Output bits 25..24 and 31..29 are zero. Input bits 31..24 have no effect on the output.
- R2: In linear mode, output bit 26 is status bit n, where n is the current frame index. For n below 32, status bit n is bit n of the loaded status word, so byte 0 comes first and each byte is sent least significant bit first. For n from 32 to 191, status bit n is zero.
- R3: Status bits 23..20 (byte 2, bits 7..4) do not come from the status word. They carry the channel index plus one as a binary number, with status bit 20 as its least significant bit. Channel index 0 therefore sends the value 1 and channel index 7 sends the value 8.
- R4: In linear mode, output bit 27 makes the number of ones in output bits 27..0 even.
- R5: In linear mode, output bit 28 is one only for channel index 0 of frame 0. It is zero for every other word.
- R6: Each accepted word advances the channel index. After the configured number of channels, the channel index returns to 0 and the frame index advances. The frame index wraps from 191 to 0.
- R7: In passthrough mode, output bits 27..0 equal input bits 31..4. Output bit 28 equals input bit 3. Output bits 31..29 are zero.
- R8: A restart strobe or a load strobe returns the next accepted word to channel 0 of frame 0. While either strobe is high, in_ready is low.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold their values. Every accepted input word appears exactly once, in order, at the output.
- R10: After reset, out_valid is low, in_ready is high, and the first word is treated as channel 0 of frame 0. The reset configuration is linear mode with 2 channels and an all-zero status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the format, channel count and status word; also rewinds the position |
| cfg_mode | input | 1 | Format: 0 selects linear, 1 selects passthrough |
| cfg_chans | input | 4 | Number of channels, 2 to 8 |
| cfg_status | input | 32 | Consumer channel-status bits 0..31 |
| restart | input | 1 | Rewinds to channel 0 of frame 0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | 32 | Linear sample or ready-made subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Formatted subframe word |

## Verification
The assertions assume three things about the inputs. The channel count lies between 2 and 8. The load and restart strobes are raised only between words and never while a word is waiting at the input. The configuration inputs matter only while the load strobe is high. The stimulus respects all three: it changes configuration only between sends, uses counts 2 through 8, and drives out_ready from a pseudo-random pattern with no extra constraint. Full 192-frame blocks are swept at the smallest and largest channel counts, so the wrap and every status position are covered.

// File: rtl/iec_fmt_pkg.sv
`timescale 1ns/1ps
// Package: shared types and bit positions for the subframe formatter.
// Assumes a 32-bit subframe word with a 24-bit linear sample field.
package iec_fmt_pkg;
    typedef enum logic {
        FMT_LINEAR   = 1'b0,
        FMT_PASSTHRU = 1'b1
    } fmt_mode_e;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned NIB_W    = 4;
endpackage

// File: rtl/iec_fmt_seq.sv
`timescale 1ns/1ps
// Module: frame/channel position sequencer.
// Counts accepted words. The channel index runs from 0 to chans-1. Each
// time it wraps, the frame index advances, and the frame index wraps at
// BLOCK_LEN. Assumes chans lies in 1..MAX_CH. clear takes priority over step.
module iec_fmt_seq #(
    parameter int unsigned MAX_CH    = 8,
    parameter int unsigned BLOCK_LEN = 192,
    localparam int unsigned CH_W     = $clog2(MAX_CH + 1),
    localparam int unsigned FR_W     = $clog2(BLOCK_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [CH_W-1:0] chans,
    output logic [CH_W-1:0] chan_idx,
    output logic [FR_W-1:0] frame_idx
);
    logic last_ch;
    logic last_fr;

    // Detects the last channel of a frame and the last frame of a block.
    always_comb begin
        last_ch = (chan_idx >= (chans - CH_W'(1)));
        last_fr = (frame_idx == FR_W'(BLOCK_LEN - 1));
    end

    // Advances the position on each accepted word; rewinds on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            chan_idx  <= '0;
            frame_idx <= '0;
        end else if (step) begin
            if (last_ch) begin
                chan_idx  <= '0;
                frame_idx <= last_fr ? '0 : frame_idx + FR_W'(1);
            end else begin
                chan_idx <= chan_idx + CH_W'(1);
            end
        end
    end

    a_r6_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx < FR_W'(BLOCK_LEN));

    a_r6_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last_ch && last_fr) |=> (frame_idx == '0 && chan_idx == '0));

    a_r8_clear_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (frame_idx == '0 && chan_idx == '0));
endmodule

// File: rtl/iec_fmt_cstat.sv
`timescale 1ns/1ps
// Module: channel-status bit selector.
// Builds one status word per channel, in which the 4-bit channel-number field
// holds index+1, and picks the bit addressed by the frame index. Frame indices
// at or beyond STATUS_BITS select zero. Purely combinational.
module iec_fmt_cstat #(
    parameter int unsigned MAX_CH      = 8,
    parameter int unsigned BLOCK_LEN   = 192,
    parameter int unsigned STATUS_BITS = 32,
    parameter int unsigned CHNUM_LSB   = 20,
    localparam int unsigned CH_W       = $clog2(MAX_CH + 1),
    localparam int unsigned FR_W       = $clog2(BLOCK_LEN),
    localparam int unsigned SEL_W      = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    localparam int unsigned STB_W      = $clog2(STATUS_BITS)
) (
    input  logic [STATUS_BITS-1:0] status_word,
    input  logic [CH_W-1:0]        chan_idx,
    input  logic [FR_W-1:0]        frame_idx,
    output logic                   cs_bit
);
    import iec_fmt_pkg::*;

    logic [STATUS_BITS-1:0] ch_word [MAX_CH];
    logic [STATUS_BITS-1:0] sel_word;

    // One status word per channel, with the channel number inserted.
    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
        assign ch_word[g] = {status_word[STATUS_BITS-1:CHNUM_LSB+NIB_W],
                             NIB_W'(g + 1),
                             status_word[CHNUM_LSB-1:0]};
    end

    // Selects this channel's word, then the bit for this frame.
    always_comb begin
        sel_word = (chan_idx < CH_W'(MAX_CH)) ? ch_word[chan_idx[SEL_W-1:0]] : '0;
        cs_bit   = (frame_idx < FR_W'(STATUS_BITS)) ? sel_word[frame_idx[STB_W-1:0]] : 1'b0;
    end
endmodule

// File: rtl/iec_fmt_pack.sv
`timescale 1ns/1ps
// Module: subframe word packer.
// In linear mode it places the sample, the status bit, even parity and the
// block-start flag. In passthrough mode it repacks a ready-made subframe.
// Purely combinational.
module iec_fmt_pack (
    input  iec_fmt_pkg::fmt_mode_e mode,
    input  logic [31:0]            in_word,
    input  logic                   cs_bit,
    input  logic                   blk_start,
    output logic [31:0]            out_word
);
    import iec_fmt_pkg::*;

    logic [26:0] body;
    logic        par;
    logic [31:0] lin_word;
    logic [31:0] pass_word;

    // Forms both candidate words and chooses the one the mode selects.
    always_comb begin
        body      = {cs_bit, 2'b00, in_word[SAMPLE_W-1:0]};
        par       = ^body;
        lin_word  = {3'b000, blk_start, par, body};
        pass_word = {3'b000, in_word[3], in_word[31:4]};
        out_word  = (mode == FMT_PASSTHRU) ? pass_word : lin_word;
    end
endmodule

// File: rtl/iec_subframe_fmt.sv
`timescale 1ns/1ps
// Module: IEC958 subframe formatter (top).
// Holds the configuration latched on cfg_load and the frame/channel position,
// and registers each formatted word in one output stage with a valid/ready
// handshake. Input is refused while a load or restart strobe is high.
module iec_subframe_fmt #(
    parameter int unsigned MAX_CH      = 8,
    parameter int unsigned BLOCK_LEN   = 192,
    parameter int unsigned STATUS_BITS = 32,
    parameter int unsigned CHNUM_LSB   = 20,
    localparam int unsigned CH_W       = $clog2(MAX_CH + 1),
    localparam int unsigned FR_W       = $clog2(BLOCK_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic                   cfg_mode,
    input  logic [CH_W-1:0]        cfg_chans,
    input  logic [STATUS_BITS-1:0] cfg_status,
    input  logic                   restart,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [31:0]            in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [31:0]            out_data
);
    import iec_fmt_pkg::*;

    fmt_mode_e              mode_q;
    fmt_mode_e              out_mode;
    logic [CH_W-1:0]        chans_q;
    logic [STATUS_BITS-1:0] status_q;
    logic [CH_W-1:0]        chan_idx;
    logic [FR_W-1:0]        frame_idx;
    logic                   accept;
    logic                   cs_bit;
    logic                   blk_start;
    logic [31:0]            packed_word;

    // Handshake: take a word when the output stage is free and no strobe is high.
    always_comb begin
        in_ready  = (!out_valid || out_ready) && !restart && !cfg_load;
        accept    = in_valid && in_ready;
        blk_start = (chan_idx == '0) && (frame_idx == '0);
    end

    // Configuration registers, loaded by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= FMT_LINEAR;
            chans_q  <= CH_W'(2);
            status_q <= '0;
        end else if (cfg_load) begin
            mode_q   <= fmt_mode_e'(cfg_mode);
            chans_q  <= cfg_chans;
            status_q <= cfg_status;
        end
    end

    iec_fmt_seq #(.MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart || cfg_load),
        .step      (accept),
        .chans     (chans_q),
        .chan_idx  (chan_idx),
        .frame_idx (frame_idx)
    );

    iec_fmt_cstat #(.MAX_CH(MAX_CH), .BLOCK_LEN(BLOCK_LEN),
                    .STATUS_BITS(STATUS_BITS), .CHNUM_LSB(CHNUM_LSB)) u_cstat (
        .status_word (status_q),
        .chan_idx    (chan_idx),
        .frame_idx   (frame_idx),
        .cs_bit      (cs_bit)
    );

    iec_fmt_pack u_pack (
        .mode      (mode_q),
        .in_word   (in_data),
        .cs_bit    (cs_bit),
        .blk_start (blk_start),
        .out_word  (packed_word)
    );

    // Output stage: captures an accepted word and drops it once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mode  <= FMT_LINEAR;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= packed_word;
            out_mode  <= mode_q;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r4_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == FMT_LINEAR) |-> (^out_data[27:0] == 1'b0));

    a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[31:29] == 3'b000));

    a_r8_no_take_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || cfg_load) |-> !in_ready);

    a_r10_valid_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/iec_subframe_fmt_tb.sv
`timescale 1ns/1ps
module iec_subframe_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [3:0]  cfg_chans = 4'd2;
    logic [31:0] cfg_status = '0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int          errs = 0;
    int          checks = 0;
    bit          stall_en = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          hold_pend = 1'b0;
    logic [31:0] hold_word = '0;

    // bench-side model state
    bit          b_mode = 1'b0;
    int          b_chans = 2;
    logic [31:0] b_status = '0;
    int          b_ch = 0;
    int          b_fr = 0;
    bit          b_r8 = 1'b0;

    always #2 clk = ~clk;

    iec_subframe_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_chans(cfg_chans), .cfg_status(cfg_status), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected word computed from the requirement text.
    function automatic logic [31:0] model(input logic [31:0] s);
        logic        cs;
        logic        b;
        logic        p;
        logic [3:0]  num;
        if (b_mode) return {3'b000, s[3], s[31:4]};
        num = 4'(b_ch + 1);
        if (b_fr >= 32)                    cs = 1'b0;
        else if (b_fr >= 20 && b_fr <= 23) cs = num[b_fr - 20];
        else                               cs = b_status[b_fr];
        b = (b_ch == 0 && b_fr == 0);
        p = ^{cs, s[23:0]};
        return {3'b000, b, p, cs, 2'b00, s[23:0]};
    endfunction

    function automatic string tag_of();
        string t;
        if (b_mode) t = "R7 R9";
        else begin
            t = "R1 R2 R4 R6 R9";
            if (b_fr >= 20 && b_fr <= 23) t = {t, " R3"};
            if (b_ch == 0 && b_fr == 0)   t = {t, " R5"};
        end
        if (b_r8) t = {t, " R8"};
        return t;
    endfunction

    // Output ready pattern, updated away from the active edge.
    always @(negedge clk) out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;

    // Monitor: compares every consumed word and checks holding under stall.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (hold_pend)
                chk(out_valid && out_data == hold_word, "R9 hold", out_data, hold_word);
            hold_pend = out_valid && !out_ready;
            hold_word = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R9 extra word", out_data, 32'h0);
                else begin
                    logic [31:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e, t, out_data, e);
                end
            end
        end
    end

    task automatic send(input logic [31:0] w);
        bit r;
        r = 1'b0;
        while (!r) begin
            @(negedge clk);
            #1;
            in_valid = 1'b1;
            in_data  = w;
            #0.5;
            r = in_ready;
            @(posedge clk);
        end
        exp_q.push_back(model(w));
        tag_q.push_back(tag_of());
        b_r8 = 1'b0;
        b_ch++;
        if (b_ch >= b_chans) begin
            b_ch = 0;
            b_fr = (b_fr == 191) ? 0 : b_fr + 1;
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic configure(input bit m, input int c, input logic [31:0] s);
        @(negedge clk);
        #1;
        cfg_mode = m; cfg_chans = 4'(c); cfg_status = s; cfg_load = 1'b1;
        #0.5;
        chk(!in_ready, "R8 ready low on load", {31'b0, in_ready}, 32'h0);
        @(posedge clk);
        #1 cfg_load = 1'b0;
        b_mode = m; b_chans = c; b_status = s; b_ch = 0; b_fr = 0; b_r8 = 1'b1;
    endtask

    task automatic do_restart();
        @(negedge clk);
        #1 restart = 1'b1;
        #0.5;
        chk(!in_ready, "R8 ready low on restart", {31'b0, in_ready}, 32'h0);
        @(posedge clk);
        #1 restart = 1'b0;
        b_ch = 0; b_fr = 0; b_r8 = 1'b1;
    endtask

    task automatic drain();
        stall_en = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n * b_chans; i++) send($urandom());
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 out_valid after reset", {31'b0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", {31'b0, in_ready}, 32'h1);
        // R10: reset configuration is linear, 2 channels, zero status
        b_r8 = 1'b0;
        frames(3);
        drain();

        // R6: two full blocks plus a few frames at 2 channels
        configure(1'b0, 2, 32'hA5C3_1E77);
        frames(2 * 192 + 10);
        drain();

        // R9: full block at 8 channels under random backpressure
        configure(1'b0, 8, 32'h5A0F_F0C1);
        stall_en = 1'b1;
        frames(192 + 3);
        drain();

        // R3: each channel count, past the channel-number field
        for (int c = 3; c <= 7; c++) begin
            configure(1'b0, c, ~32'(c * 32'h1357_9BDF));
            stall_en = (c % 2) == 1;
            frames(26);
            drain();
        end

        // R7: passthrough under backpressure
        configure(1'b1, 6, 32'hFFFF_FFFF);
        stall_en = 1'b1;
        for (int i = 0; i < 300; i++) send($urandom());
        drain();

        // R8: restart mid-block, then reload mid-block
        configure(1'b0, 4, 32'h0123_4567);
        frames(5);
        send($urandom());
        do_restart();
        frames(3);
        send($urandom());
        configure(1'b0, 2, 32'hDEAD_BEEF);
        frames(4);
        drain();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule